// File: doc/BRIEF.md
# Weighted Pseudo-Random Bit Source on a Hybrid Cellular Automaton

This block supplies a set of pseudo-random bit-streams for a built-in self-test pattern generator. Each stream has its own probability of being 1. One shared M-cell cellular automaton register provides the randomness. The register advances one step per enabled clock. Each cell takes rule 90 or rule 150 as a parameter mask selects, and the cells beyond both ends read as zero.

A raw cell gives a bit that is 1 with probability one half. The other probabilities come from small AND/OR combinations of distinct cells: a quarter, five eighths, three quarters, seven eighths and fifteen sixteenths. A tester or a controller can reload the register in parallel with a new seed. A seed of all zeros would lock the automaton, so it is replaced with a fixed nonzero value. Routing the streams to particular inputs of the circuit under test happens outside this block.

Top module: `ca_wrs_source`

## Requirements
- R1: While `rst_n` is low the register holds the parameter `RESET_SEED`, and the outputs reflect that state in the cycle after release.
- R2: Tap slot k reads cell (k mod M). The outputs are combinational functions of the present register: `w_half` = slot0; `w_quarter` = slot1 AND slot2; `w_five_eighths` = slot3 OR (slot4 AND slot5); `w_three_quarters` = slot6 OR slot7; `w_seven_eighths` = slot8 OR slot9 OR slot10; `w_fifteen_sixteenths` = slot11 OR slot12 OR slot13 OR slot14.
- R3: When `load` is high and `seed` is nonzero, the register takes `seed` at the next edge, whatever the value of `en`.
- R4: When `load` is high and `seed` is all zeros, the register takes the parameter `ZERO_FIX` (nonzero) at the next edge.
- R5: With `load` and `en` both low the register keeps its value, and `seed` has no effect.
- R6: With `en` high and `load` low, cell i becomes cell(i-1) XOR cell(i+1) XOR (`RULE[i]` AND cell i), where a neighbour outside 0..M-1 reads as 0.
- R7: With M=4 and `RULE`=4'b1011 the sequence has period 15. Over one period the number of cycles each output is 1 equals its weight times 16: 4, 8, 10, 12, 14 and 15 for a quarter, a half, five eighths, three quarters, seven eighths and fifteen sixteenths.
- R8: When the rule mask gives an invertible update, the register is never all zeros after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the automaton one step |
| load | input | 1 | Parallel seed load, has priority over `en` |
| seed | input | M | Seed value for a load |
| w_quarter | output | 1 | Stream with weight 0.25 |
| w_half | output | 1 | Stream with weight 0.5 |
| w_five_eighths | output | 1 | Stream with weight 0.625 |
| w_three_quarters | output | 1 | Stream with weight 0.75 |
| w_seven_eighths | output | 1 | Stream with weight 0.875 |
| w_fifteen_sixteenths | output | 1 | Stream with weight 0.9375 |

## Verification
A seed load and an automaton step can be requested in the same cycle. The bench provokes this by loading each of the sixteen 4-bit seeds once with `en` low and once with `en` high. In both cases it expects the loaded value (or the zero replacement) and never the stepped state. After each load one plain step follows and is compared with the rule computed in the bench. A full period is then walked, and the number of ones on each output is counted against the weights.

// File: rtl/ca_wrs_pkg.sv
package ca_wrs_pkg;

    // One bit per supported weight.
    typedef struct packed {
        logic quarter;
        logic half;
        logic five_eighths;
        logic three_quarters;
        logic seven_eighths;
        logic fifteen_sixteenths;
    } wbits_t;

    // Number of tap slots the weight trees use.
    localparam int TAP_SLOTS = 15;

    // Maps a tap slot onto a register cell.
    function automatic int tap_cell(input int slot, input int width);
        return slot % width;
    endfunction

endpackage

// File: rtl/ca_wrs_step.sv
module ca_wrs_step #(
    parameter int          M    = 24,
    parameter logic [M-1:0] RULE = '1
) (
    input  logic [M-1:0] cells_i,
    output logic [M-1:0] cells_o
);

    for (genvar i = 0; i < M; i++) begin : g_cell
        logic lower_nb;
        logic upper_nb;
        if (i == 0) begin : g_lo_edge
            assign lower_nb = 1'b0;
        end else begin : g_lo_mid
            assign lower_nb = cells_i[i-1];
        end
        if (i == M - 1) begin : g_hi_edge
            assign upper_nb = 1'b0;
        end else begin : g_hi_mid
            assign upper_nb = cells_i[i+1];
        end
        // Rule 150 adds the cell itself, rule 90 uses the neighbours only.
        assign cells_o[i] = lower_nb ^ upper_nb ^ (RULE[i] & cells_i[i]);
    end

endmodule

// File: rtl/ca_wrs_shaper.sv
module ca_wrs_shaper
    import ca_wrs_pkg::*;
#(
    parameter int M = 24
) (
    input  logic [M-1:0] cells_i,
    output wbits_t       weights_o
);

    localparam int S0  = tap_cell(0, M);
    localparam int S1  = tap_cell(1, M);
    localparam int S2  = tap_cell(2, M);
    localparam int S3  = tap_cell(3, M);
    localparam int S4  = tap_cell(4, M);
    localparam int S5  = tap_cell(5, M);
    localparam int S6  = tap_cell(6, M);
    localparam int S7  = tap_cell(7, M);
    localparam int S8  = tap_cell(8, M);
    localparam int S9  = tap_cell(9, M);
    localparam int S10 = tap_cell(10, M);
    localparam int S11 = tap_cell(11, M);
    localparam int S12 = tap_cell(12, M);
    localparam int S13 = tap_cell(13, M);
    localparam int S14 = tap_cell(14, M);

    always_comb begin
        weights_o                    = '0;
        weights_o.half               = cells_i[S0];
        weights_o.quarter            = cells_i[S1] & cells_i[S2];
        weights_o.five_eighths       = cells_i[S3] | (cells_i[S4] & cells_i[S5]);
        weights_o.three_quarters     = cells_i[S6] | cells_i[S7];
        weights_o.seven_eighths      = cells_i[S8] | cells_i[S9] | cells_i[S10];
        weights_o.fifteen_sixteenths = cells_i[S11] | cells_i[S12] |
                                       cells_i[S13] | cells_i[S14];
    end

endmodule

// File: rtl/ca_wrs_source.sv
module ca_wrs_source
    import ca_wrs_pkg::*;
#(
    parameter int           M          = 24,
    parameter logic [M-1:0] RULE       = '1,
    parameter logic [M-1:0] RESET_SEED = {{(M-1){1'b0}}, 1'b1},
    parameter logic [M-1:0] ZERO_FIX   = {1'b1, {(M-1){1'b0}}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [M-1:0] seed,
    output logic         w_quarter,
    output logic         w_half,
    output logic         w_five_eighths,
    output logic         w_three_quarters,
    output logic         w_seven_eighths,
    output logic         w_fifteen_sixteenths
);

    localparam logic [M-1:0] ALL_ZERO = '0;

    typedef struct packed {
        logic [M-1:0] cells;
    } ca_state_t;

    ca_state_t    st_d, st_q;
    logic [M-1:0] cells_stepped;
    wbits_t       weights;

    ca_wrs_step #(
        .M    (M),
        .RULE (RULE)
    ) u_step (
        .cells_i (st_q.cells),
        .cells_o (cells_stepped)
    );

    ca_wrs_shaper #(
        .M (M)
    ) u_shaper (
        .cells_i   (st_q.cells),
        .weights_o (weights)
    );

    // Next-state selection: load wins over enable.
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cells = (seed == ALL_ZERO) ? ZERO_FIX : seed;
        end else if (en) begin
            st_d.cells = cells_stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cells <= RESET_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign w_quarter            = weights.quarter;
    assign w_half               = weights.half;
    assign w_five_eighths       = weights.five_eighths;
    assign w_three_quarters     = weights.three_quarters;
    assign w_seven_eighths      = weights.seven_eighths;
    assign w_fifteen_sixteenths = weights.fifteen_sixteenths;

    AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed != ALL_ZERO) |=> st_q.cells == $past(seed)); // R3

    AST_ZERO_SEED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == ALL_ZERO) |=> st_q.cells == ZERO_FIX); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> $stable(st_q.cells)); // R5

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cells != ALL_ZERO); // R8

endmodule

// File: tb/ca_wrs_source_tb.sv
module ca_wrs_source_tb;

    localparam int           CLK_PERIOD = 10;
    localparam int           M          = 4;
    localparam logic [M-1:0] RULE       = 4'b1011;
    localparam logic [M-1:0] RESET_SEED = 4'b0001;
    localparam logic [M-1:0] ZERO_FIX   = 4'b1000;
    localparam int           PERIOD     = (1 << M) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         load = 1'b0;
    logic [M-1:0] seed = '0;
    logic         w_quarter, w_half, w_five_eighths;
    logic         w_three_quarters, w_seven_eighths, w_fifteen_sixteenths;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ca_wrs_source #(
        .M          (M),
        .RULE       (RULE),
        .RESET_SEED (RESET_SEED),
        .ZERO_FIX   (ZERO_FIX)
    ) u_dut (
        .clk                  (clk),
        .rst_n                (rst_n),
        .en                   (en),
        .load                 (load),
        .seed                 (seed),
        .w_quarter            (w_quarter),
        .w_half               (w_half),
        .w_five_eighths       (w_five_eighths),
        .w_three_quarters     (w_three_quarters),
        .w_seven_eighths      (w_seven_eighths),
        .w_fifteen_sixteenths (w_fifteen_sixteenths)
    );

    // Rule of R6 applied to a bench-held state.
    function automatic logic [M-1:0] ca_next(input logic [M-1:0] s);
        logic [M-1:0] n;
        for (int i = 0; i < M; i++) begin
            logic lo, hi;
            lo   = (i > 0)     ? s[i-1] : 1'b0;
            hi   = (i < M - 1) ? s[i+1] : 1'b0;
            n[i] = lo ^ hi ^ (RULE[i] & s[i]);
        end
        return n;
    endfunction

    // Tap formulas of R2, order {quarter, half, 5/8, 3/4, 7/8, 15/16}.
    function automatic logic [5:0] weights_of(input logic [M-1:0] s);
        logic [14:0] t;
        for (int k = 0; k < 15; k++) t[k] = s[k % M];
        return {t[1] & t[2], t[0], t[3] | (t[4] & t[5]), t[6] | t[7],
                t[8] | t[9] | t[10], t[11] | t[12] | t[13] | t[14]};
    endfunction

    function automatic logic [5:0] outs();
        return {w_quarter, w_half, w_five_eighths, w_three_quarters,
                w_seven_eighths, w_fifteen_sixteenths};
    endfunction

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Inputs change at the falling edge; results are read one falling edge later.
    task automatic cycle(input logic l, input logic e, input logic [M-1:0] s);
        load = l;
        en   = e;
        seed = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [M-1:0] model;
        int           ones [6];
        int           want [6];
        want = '{4, 8, 10, 12, 14, 15};

        repeat (2) @(negedge clk);
        check("R1 reset state", outs(), weights_of(RESET_SEED));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", outs(), weights_of(RESET_SEED));
        model = RESET_SEED;

        // R5: idle cycles with a changing seed leave the state alone.
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b0, M'(k + 6));
            check("R5 idle hold", outs(), weights_of(model));
        end
        cycle(1'b0, 1'b1, '0);
        model = ca_next(model);
        check("R5 state kept before step R6", outs(), weights_of(model));

        // R3/R4: every seed, loaded with enable low and high, then one step (R6).
        for (int v = 0; v < (1 << M); v++) begin
            for (int e = 0; e < 2; e++) begin
                logic [M-1:0] sv;
                sv    = M'(v);
                model = (sv == '0) ? ZERO_FIX : sv;
                cycle(1'b1, e[0], sv);
                check((sv == '0) ? "R4 zero seed replaced" : "R3 seed load priority",
                      outs(), weights_of(model));
                cycle(1'b0, 1'b1, '0);
                model = ca_next(model);
                check("R6 single step", outs(), weights_of(model));
            end
        end

        // R7/R8: walk a full period from seed 1 and count ones per output.
        for (int j = 0; j < 6; j++) ones[j] = 0;
        cycle(1'b1, 1'b0, 4'b0001);
        model = 4'b0001;
        for (int k = 0; k < PERIOD; k++) begin
            logic [5:0] o;
            cycle(1'b0, 1'b1, '0);
            model = ca_next(model);
            o = outs();
            check("R6 period walk", o, weights_of(model));
            check("R8 register nonzero", {5'b0, o[0]}, 6'b000001);
            for (int j = 0; j < 6; j++) ones[j] += int'(o[5 - j]);
        end
        check_int("R7 period returns to seed", int'(model), 1);
        check("R7 state after period", outs(), weights_of(4'b0001));
        for (int j = 0; j < 6; j++) check_int("R7 ones per period", ones[j], want[j]);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule